// File: doc/BRIEF.md
# Erase-Block Write-Protection Manager

This block holds a write-protection state for every erase block of a flash array. Each block is in one of three states: open (programmable), locked, or lock-tight. Lock-tight can only be left through reset. Software first sets a start-block and an end-block register. It then issues one of four commands: open a range, open every block, lock a range, or lock-tight a range. The block walks the affected blocks one per clock, holds `busy_o` high while it walks, and pulses `done_o` when the walk ends.

The program and erase logic ask whether a block may be altered through a combinational query port. A status register holds the state most recently written to any block. The flash array storage is not part of this block.

Top module: `wp_guard`

## Requirements
- R1: After reset every block reads locked, the status register reads 0x0002, both range registers read 0, and `busy_o`, `done_o` and `cmd_err_o` are low.
- R2: States are one-hot: 3'b001 is lock-tight, 3'b010 is locked and 3'b100 is open. The query port returns the state of `qry_blk_i` in the same cycle. `qry_wr_ok_o` is high only for an open block. An index at or above NUM_BLK reads locked.
- R3: A start-register write keeps the low IDX_W bits of the data and also loads the same value into the end register. An end-register write keeps the low IDX_W bits and changes only the end register.
- R4: Command 0x23 opens blocks start..end inclusive, one block per clock. `busy_o` stays high for exactly one cycle per visited block.
- R5: Command 0x2A locks blocks start..end inclusive, one block per clock.
- R6: A 0x23 or 0x2A walk that reaches a lock-tight block ends there. Blocks already visited keep their new state. The lock-tight block and all blocks after it are untouched.
- R7: Command 0x2C turns visited locked blocks into lock-tight and passes over open blocks without ending the walk. No command ever changes a lock-tight block.
- R8: Command 0x27 walks from block 0 to NUM_BLK-1, opening each block. It ends at the first lock-tight block.
- R9: Every block written by a walk loads its new state, zero-extended, into the status register. A walk that writes nothing leaves the status register unchanged.
- R10: If a range walk reaches an index at or above NUM_BLK, it ends and `cmd_err_o` pulses together with `done_o`.
- R11: `done_o` pulses for one cycle, in the first cycle after the last busy cycle, whether the walk ended normally or early. A range whose start is above its end takes one busy cycle and changes nothing.
- R12: Commands that arrive while busy, and any code other than the four listed, are ignored. A walk uses the range values held when it was accepted, even if a range register is written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_we_i | input | 1 | Write strobe for the start-block register |
| end_we_i | input | 1 | Write strobe for the end-block register |
| reg_wdata_i | input | DATA_W | Range register write data |
| start_blk_o | output | IDX_W | Start-block register |
| end_blk_o | output | IDX_W | End-block register |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err_o | output | 1 | One-cycle pulse when a walk ran past the last block |
| wp_status_o | output | 16 | Last state written to any block |
| qry_blk_i | input | IDX_W | Block index to query |
| qry_state_o | output | 3 | One-hot state of the queried block |
| qry_wr_ok_o | output | 1 | Queried block is open |

## Verification
A range register write can fall in the same cycle that a command is accepted. Both then compete for the range values. The bench writes the start register, with a value different from the current range, in the very cycle it issues a lock command. It judges the result by the blocks that change: they must follow the old start..end range. Afterwards both range registers must read the new value. During that same walk, a second command is sent while busy is high. It must leave no trace on any block or on the walk length.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int STAT_W = 16;

  typedef enum logic [2:0] {
    WP_TIGHT  = 3'b001,
    WP_LOCKED = 3'b010,
    WP_OPEN   = 3'b100
  } wp_state_e;

  typedef enum logic [7:0] {
    OP_OPEN     = 8'h23,
    OP_OPEN_ALL = 8'h27,
    OP_LOCK     = 8'h2A,
    OP_TIGHT    = 8'h2C
  } wp_op_e;
endpackage

// File: rtl/wpg_range.sv
module wpg_range #(
  parameter int NUM_BLK = 64,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  lo_o,
  output logic [IDX_W-1:0]  hi_o
);
  logic [IDX_W-1:0] lo_q, hi_q;
  logic [IDX_W-1:0] wval;
  logic             unused_wdata_hi;

  assign wval            = wdata_i[IDX_W-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we_i) lo_q <= wval;
      // start write also rewrites end
      if (lo_we_i || hi_we_i) hi_q <= wval;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  a_r3_end_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> (hi_q == lo_q));
endmodule

// File: rtl/wpg_blocks.sv
module wpg_blocks
  import wpg_pkg::*;
#(
  parameter int NUM_BLK = 64,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  wp_state_e         wr_val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output wp_state_e         rd_st_o,
  input  logic [IDX_W-1:0]  qry_idx_i,
  output wp_state_e         qry_st_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [IDX_W:0] NUM_W = (IDX_W+1)'(NUM_BLK);

  wp_state_e          st_q [NUM_BLK];
  logic [STAT_W-1:0]  stat_q;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  st_q[g] <= WP_LOCKED;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    st_q[g] <= wr_val_i;
    end

    a_r2_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(st_q[g]) == 1);
    a_r7_tight_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == WP_TIGHT) |=> (st_q[g] == WP_TIGHT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= STAT_W'(16'h0002);
    else if (wr_en_i) stat_q <= STAT_W'(wr_val_i);
  end

  assign rd_st_o  = ({1'b0, rd_idx_i}  < NUM_W) ? st_q[rd_idx_i]  : WP_LOCKED;
  assign qry_st_o = ({1'b0, qry_idx_i} < NUM_W) ? st_q[qry_idx_i] : WP_LOCKED;
  assign stat_o   = stat_q;
endmodule

// File: rtl/wpg_walker.sv
module wpg_walker
  import wpg_pkg::*;
#(
  parameter int NUM_BLK = 64,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_code_i,
  input  logic [IDX_W-1:0] lo_i,
  input  logic [IDX_W-1:0] hi_i,
  input  wp_state_e        cur_st_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output wp_state_e        wr_val_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [IDX_W:0]   NUM_W  = (IDX_W+1)'(NUM_BLK);
  localparam logic [IDX_W-1:0] LAST_B = IDX_W'(NUM_BLK - 1);

  wp_op_e           op_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             busy_q, done_q, err_q;
  logic             known, launch;
  logic             past_end, oob, blocked, skip, stop;

  always_comb begin
    unique case (cmd_code_i)
      OP_OPEN, OP_OPEN_ALL, OP_LOCK, OP_TIGHT: known = 1'b1;
      default:                                 known = 1'b0;
    endcase
  end

  assign launch = cmd_valid_i && known && !busy_q;

  always_comb begin
    past_end = idx_q > last_q;
    oob      = {1'b0, idx_q} >= NUM_W;
    blocked  = (op_q != OP_TIGHT) && (cur_st_i == WP_TIGHT);
    skip     = (op_q == OP_TIGHT) && (cur_st_i == WP_OPEN);
    wr_en_o  = busy_q && !past_end && !oob && !blocked && !skip;
    stop     = past_end || oob || blocked || (idx_q == last_q);
    unique case (op_q)
      OP_LOCK:  wr_val_o = WP_LOCKED;
      OP_TIGHT: wr_val_o = WP_TIGHT;
      default:  wr_val_o = WP_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_OPEN;
      idx_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (launch) begin
          busy_q <= 1'b1;
          op_q   <= wp_op_e'(cmd_code_i);
          if (cmd_code_i == OP_OPEN_ALL) begin
            idx_q  <= '0;
            last_q <= LAST_B;
          end else begin
            idx_q  <= lo_i;
            last_q <= hi_i;
          end
        end
      end else if (stop) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= oob && !past_end;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign rd_idx_o = idx_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  a_r11_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q);
  a_r12_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_q);
  a_r12_busy_holds_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(op_q));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int NUM_BLK = 64,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_we_i,
  input  logic              end_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [IDX_W-1:0]  start_blk_o,
  output logic [IDX_W-1:0]  end_blk_o,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cmd_err_o,
  output logic [15:0]       wp_status_o,
  input  logic [IDX_W-1:0]  qry_blk_i,
  output logic [2:0]        qry_state_o,
  output logic              qry_wr_ok_o
);
  logic [IDX_W-1:0] rd_idx;
  wp_state_e        rd_st, wr_val, qry_st;
  logic             wr_en;

  wpg_range #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_range (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (start_we_i),
    .hi_we_i (end_we_i),
    .wdata_i (reg_wdata_i),
    .lo_o    (start_blk_o),
    .hi_o    (end_blk_o)
  );

  wpg_walker #(.NUM_BLK(NUM_BLK)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .lo_i        (start_blk_o),
    .hi_i        (end_blk_o),
    .cur_st_i    (rd_st),
    .rd_idx_o    (rd_idx),
    .wr_en_o     (wr_en),
    .wr_val_o    (wr_val),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (cmd_err_o)
  );

  wpg_blocks #(.NUM_BLK(NUM_BLK)) u_blocks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (rd_idx),
    .wr_val_i  (wr_val),
    .rd_idx_i  (rd_idx),
    .rd_st_o   (rd_st),
    .qry_idx_i (qry_blk_i),
    .qry_st_o  (qry_st),
    .stat_o    (wp_status_o)
  );

  assign qry_state_o = qry_st;
  assign qry_wr_ok_o = (qry_st == WP_OPEN);
endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int   tgt = 0;
  logic cv = 0, swe = 0, ewe = 0;
  logic [7:0]  code = 0;
  logic [15:0] wdata = 0;
  logic [5:0]  qry = 0;

  logic [5:0]  s0, e0, s1, e1;
  logic        b0, d0, x0, b1, d1, x1, ok0, ok1;
  logic [15:0] st0, st1;
  logic [2:0]  q0, q1;

  wp_guard u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .start_we_i(swe && tgt == 0), .end_we_i(ewe && tgt == 0), .reg_wdata_i(wdata),
    .start_blk_o(s0), .end_blk_o(e0),
    .cmd_valid_i(cv && tgt == 0), .cmd_code_i(code),
    .busy_o(b0), .done_o(d0), .cmd_err_o(x0), .wp_status_o(st0),
    .qry_blk_i(qry), .qry_state_o(q0), .qry_wr_ok_o(ok0)
  );

  wp_guard #(.NUM_BLK(40)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .start_we_i(swe && tgt == 1), .end_we_i(ewe && tgt == 1), .reg_wdata_i(wdata),
    .start_blk_o(s1), .end_blk_o(e1),
    .cmd_valid_i(cv && tgt == 1), .cmd_code_i(code),
    .busy_o(b1), .done_o(d1), .cmd_err_o(x1), .wp_status_o(st1),
    .qry_blk_i(qry), .qry_state_o(q1), .qry_wr_ok_o(ok1)
  );

  wire [5:0]  o_s    = tgt == 1 ? s1  : s0;
  wire [5:0]  o_e    = tgt == 1 ? e1  : e0;
  wire        o_busy = tgt == 1 ? b1  : b0;
  wire        o_done = tgt == 1 ? d1  : d0;
  wire        o_err  = tgt == 1 ? x1  : x0;
  wire [15:0] o_stat = tgt == 1 ? st1 : st0;
  wire [2:0]  o_q    = tgt == 1 ? q1  : q0;
  wire        o_ok   = tgt == 1 ? ok1 : ok0;

  int checks = 0;
  int errors = 0;

  logic [2:0]  expst [2][64];
  int          nb [2] = '{64, 40};
  int          mlo [2], mhi [2];
  logic [15:0] mstat [2];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_start(input int v);
    @(negedge clk); swe = 1; wdata = 16'(v);
    @(negedge clk); swe = 0;
    mlo[tgt] = v & 63; mhi[tgt] = v & 63;
  endtask

  task automatic wr_end(input int v);
    @(negedge clk); ewe = 1; wdata = 16'(v);
    @(negedge clk); ewe = 0;
    mhi[tgt] = v & 63;
  endtask

  task automatic check_all(input string req);
    int bad = 0;
    for (int i = 0; i < nb[tgt]; i++) begin
      qry = 6'(i); #1;
      if (o_q != expst[tgt][i] || o_ok != (expst[tgt][i] == 3'b100)) begin
        bad++;
        $display("FAIL %s block %0d actual=%0h expected=%0h", req, i, o_q, expst[tgt][i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic m_walk(input logic [7:0] c, output int cyc, output bit er);
    int t = tgt;
    int n = nb[t];
    int i, last;
    cyc = 0; er = 0;
    i    = (c == 8'h27) ? 0 : mlo[t];
    last = (c == 8'h27) ? n - 1 : mhi[t];
    forever begin
      cyc++;
      if (i > last) break;
      if (i >= n) begin er = 1; break; end
      if (c != 8'h2C && expst[t][i] == 3'b001) break;
      if (c == 8'h2C) begin
        if (expst[t][i] != 3'b100) begin expst[t][i] = 3'b001; mstat[t] = 16'h0001; end
      end else begin
        expst[t][i] = (c == 8'h2A) ? 3'b010 : 3'b100;
        mstat[t] = 16'(expst[t][i]);
      end
      if (i == last) break;
      i++;
    end
  endtask

  // inj_start >= 0: start register written in the launch cycle; inj_busy: command sent mid-walk
  task automatic run(input logic [7:0] c, input string req, input int inj_start, input bit inj_busy);
    int cyc, cnt;
    bit er;
    m_walk(c, cyc, er);
    @(negedge clk); cv = 1; code = c;
    if (inj_start >= 0) begin swe = 1; wdata = 16'(inj_start); end
    @(negedge clk); cv = 0; swe = 0;
    if (inj_start >= 0) begin mlo[tgt] = inj_start & 63; mhi[tgt] = inj_start & 63; end
    cnt = 0;
    while (o_busy && cnt < 300) begin
      cnt++;
      if (o_done) chk({req, " done during walk"}, 1, 0);
      if (inj_busy && cnt == 2) begin cv = 1; code = 8'h23; end
      else cv = 0;
      @(negedge clk);
    end
    cv = 0;
    chk({req, " busy cycles"}, cnt, cyc);
    chk({req, " R11 done pulse"}, int'(o_done), 1);
    chk({req, " R10 error flag"}, int'(o_err), int'(er));
    @(negedge clk);
    chk({req, " R11 done one cycle"}, int'(o_done), 0);
    chk({req, " R9 status"}, int'(o_stat), int'(mstat[tgt]));
    check_all({req, " block states"});
  endtask

  task automatic t_reset();
    for (int t = 0; t < 2; t++) begin
      tgt = t;
      #1;
      chk("R1 status", int'(o_stat), 16'h0002);
      chk("R1 busy", int'(o_busy), 0);
      chk("R1 done", int'(o_done), 0);
      chk("R1 err", int'(o_err), 0);
      chk("R1 start", int'(o_s), 0);
      chk("R1 end", int'(o_e), 0);
      check_all("R1 all locked");
    end
    tgt = 0;
  endtask

  task automatic t_regs();
    wr_start(16'hFFC5); #1;
    chk("R3 start masked", int'(o_s), 5);
    chk("R3 end copied", int'(o_e), 5);
    wr_end(16'h004A); #1;
    chk("R3 end masked", int'(o_e), 10);
    chk("R3 start kept", int'(o_s), 5);
  endtask

  task automatic t_unknown();
    @(negedge clk); cv = 1; code = 8'h55;
    @(negedge clk); cv = 0;
    chk("R12 unknown not busy", int'(o_busy), 0);
    @(negedge clk);
    chk("R12 unknown no done", int'(o_done), 0);
    chk("R12 unknown status", int'(o_stat), int'(mstat[tgt]));
    check_all("R12 unknown states");
  endtask

  task automatic t_concurrent();
    wr_start(40); wr_end(50);
    run(8'h23, "R4 open 40..50", -1, 0);
    run(8'h2A, "R12 launch with start write", 45, 1);
    #1;
    chk("R12 start after launch write", int'(o_s), 45);
    chk("R12 end after launch write", int'(o_e), 45);
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < 64; i++) expst[t][i] = 3'b010;
      mlo[t] = 0; mhi[t] = 0; mstat[t] = 16'h0002;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    wr_start(4); wr_end(9);
    run(8'h23, "R4 open 4..9", -1, 0);
    wr_start(0); wr_end(7);
    run(8'h2C, "R7 tight 0..7", -1, 0);
    wr_start(8); wr_end(12);
    run(8'h2A, "R5 lock 8..12", -1, 0);
    wr_start(30);
    run(8'h2C, "R7 tight 30", -1, 0);
    wr_start(27); wr_end(33);
    run(8'h23, "R6 open stops at 30", -1, 0);
    run(8'h23, "R7 tight block 30 untouched", -1, 0);
    run(8'h27, "R8 open all stops at 0", -1, 0);
    wr_start(10); wr_end(5);
    run(8'h23, "R11 empty range", -1, 0);
    t_unknown();
    t_concurrent();
    tgt = 1;
    run(8'h27, "R8 open all 40", -1, 0);
    wr_start(38); wr_end(45);
    run(8'h2A, "R10 walk past last", -1, 0);
    qry = 6'd50; #1;
    chk("R2 out-of-range query state", int'(o_q), 3'b010);
    chk("R2 out-of-range query write-ok", int'(o_ok), 0);
    qry = 6'd20; #1;
    chk("R2 open block write-ok", int'(o_ok), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule